// File: doc/BRIEF.md
# Layered LDPC Iteration Sequencer

This block drives a layered quasi-cyclic LDPC decoder whose base matrix has 7 layers and 8 block columns, lifted by 32 (224 checks, 256 variables). A start pulse launches a decode. The sequencer then walks the layers in ascending order. Each layer takes three cycles: a read phase, an update phase and a write phase. The layer index and a one-hot phase enable go out to the node processing arrays. The node arithmetic and the cyclic shift network sit outside this block.

In every write phase the processing side presents the hard-decision signs of the 8 columns, already aligned to the current layer. From these the sequencer forms the 32 parity checks of that layer and adds their failure count to a running syndrome weight. After the seventh layer comes one check cycle. There the iteration either ends the decode or starts the next pass. The decode ends when the syndrome weight is zero and early exit is enabled, or when the iteration limit is reached. The block then reports the iteration count, the syndrome weight of the final iteration and a converged flag.

Top module: `ldpc_layer_sequencer`

## Requirements
- R1: After reset, busy_o, converged_o, iters_used_o, synd_weight_o, rd_en_o, upd_en_o and wr_en_o are all 0.
- R2: A start_i pulse sampled while not busy makes busy_o, rd_en_o and layer 0 appear in the next cycle. The iteration limit and the early-exit enable are captured at that edge.
- R3: Each iteration runs 22 busy cycles. For each layer 0..6 in ascending order there is one cycle each of rd_en_o, upd_en_o and wr_en_o, with layer_o held. Then comes one check cycle with no enable high. At most one enable is high in any cycle.
- R4: Bit c of layer check vector = XOR over column j=0..7 of col_signs_i[j*32+c], sampled only in wr_en_o cycles. The syndrome weight of an iteration is the count of failing checks summed over its 7 layers (0..224). col_signs_i has no effect in other cycles.
- R5: With early exit enabled, the decode ends after the first iteration whose syndrome weight is zero.
- R6: With early exit disabled, the decode always runs the full iteration limit, even when the syndrome is zero.
- R7: iter_limit_i values 1..30 give that many iterations at most. The values 0 and 31 act as 30.
- R8: busy_o falls in the cycle after the check cycle of the final iteration. From then on iters_used_o holds the number of iterations run and synd_weight_o holds the final iteration's weight. Both stay stable until the next start.
- R9: converged_o is 1 exactly when the final syndrome weight is zero. It is cleared by a start.
- R10: start_i while busy_o is 1 is ignored. It neither restarts the decode nor changes the captured limit or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a decode (single-cycle pulse) |
| early_exit_en_i | input | 1 | Enable exit on zero syndrome |
| iter_limit_i | input | 5 | Iteration limit; 0 or above 30 means 30 |
| col_signs_i | input | 256 | Aligned hard-decision signs, 32 bits per column |
| busy_o | output | 1 | Decode in progress |
| rd_en_o | output | 1 | Read phase enable |
| upd_en_o | output | 1 | Update phase enable |
| wr_en_o | output | 1 | Write phase enable |
| layer_o | output | 3 | Current layer index |
| converged_o | output | 1 | Final syndrome was zero |
| iters_used_o | output | 5 | Iterations completed |
| synd_weight_o | output | 8 | Syndrome weight of last finished iteration |

## Verification
Inputs change only at falling edges. Every result is read at a falling edge that follows the rising edge that produces it.
- The first read phase for layer 0 is due one cycle after the start edge.
- For each busy cycle, the bench predicts the phase and layer from the cycle's position in the 22-cycle iteration and compares them.
- The sign word for a layer is driven at the falling edge inside that layer's write cycle, so the design captures it at the following rising edge. All other cycles carry random junk.
- The final iteration count, weight and converged flag are compared at the first falling edge where busy is low. The busy length is compared against 22 times the expected iteration count.
- The outputs are compared again a few cycles later to confirm they hold.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_UPDATE,
    ST_WRITE,
    ST_CHECK,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/layer_parity_unit.sv
module layer_parity_unit #(
  parameter int N_COLS = 8,
  parameter int Z      = 32,
  localparam int CW    = $clog2(Z + 1)
) (
  input  logic [N_COLS*Z-1:0] col_signs_i,
  output logic [CW-1:0]       fail_cnt_o
);
  logic [Z-1:0] fail;

  for (genvar c = 0; c < Z; c++) begin : g_chk
    logic [N_COLS-1:0] bits;
    for (genvar j = 0; j < N_COLS; j++) begin : g_col
      assign bits[j] = col_signs_i[j*Z + c];
    end
    assign fail[c] = ^bits;
  end

  always_comb begin
    fail_cnt_o = '0;
    for (int i = 0; i < Z; i++) fail_cnt_o = fail_cnt_o + CW'(fail[i]);
  end
endmodule

// File: rtl/iter_limit_clamp.sv
module iter_limit_clamp #(
  parameter int ITER_W   = 5,
  parameter int MAX_ITER = 30
) (
  input  logic [ITER_W-1:0] raw_i,
  output logic [ITER_W-1:0] lim_o
);
  localparam logic [ITER_W-1:0] MaxV = ITER_W'(MAX_ITER);
  assign lim_o = (raw_i == '0 || raw_i > MaxV) ? MaxV : raw_i;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ldpc_seq_pkg::*;
#(
  parameter int N_LAYERS = 7,
  parameter int Z        = 32,
  parameter int ITER_W   = 5,
  parameter int MAX_ITER = 30,
  localparam int LAYER_W = $clog2(N_LAYERS),
  localparam int CW      = $clog2(Z + 1),
  localparam int WGT_W   = $clog2(N_LAYERS * Z + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               early_en_i,
  input  logic [ITER_W-1:0]  lim_i,
  input  logic [CW-1:0]      layer_fail_i,
  output logic               busy_o,
  output logic               rd_en_o,
  output logic               upd_en_o,
  output logic               wr_en_o,
  output logic [LAYER_W-1:0] layer_o,
  output logic               converged_o,
  output logic [ITER_W-1:0]  iters_used_o,
  output logic [WGT_W-1:0]   synd_weight_o
);
  seq_state_e         state_q;
  logic [LAYER_W-1:0] layer_q;
  logic [ITER_W-1:0]  iter_q, lim_q, iters_q;
  logic               early_q, conv_q;
  logic [WGT_W-1:0]   acc_q, weight_q;
  logic [ITER_W-1:0]  iter_nxt;
  logic               last_layer, finish;

  assign iter_nxt   = iter_q + ITER_W'(1);
  assign last_layer = (layer_q == LAYER_W'(N_LAYERS - 1));
  assign finish     = (iter_nxt == lim_q) || (early_q && acc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      layer_q  <= '0;
      iter_q   <= '0;
      lim_q    <= ITER_W'(MAX_ITER);
      early_q  <= 1'b0;
      acc_q    <= '0;
      weight_q <= '0;
      iters_q  <= '0;
      conv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q  <= ST_READ;
          layer_q  <= '0;
          iter_q   <= '0;
          acc_q    <= '0;
          lim_q    <= lim_i;
          early_q  <= early_en_i;
          conv_q   <= 1'b0;
          iters_q  <= '0;
          weight_q <= '0;
        end
        ST_READ:   state_q <= ST_UPDATE;
        ST_UPDATE: state_q <= ST_WRITE;
        ST_WRITE: begin
          acc_q <= acc_q + WGT_W'(layer_fail_i);
          if (last_layer) state_q <= ST_CHECK;
          else begin
            state_q <= ST_READ;
            layer_q <= layer_q + LAYER_W'(1);
          end
        end
        ST_CHECK: begin
          weight_q <= acc_q;
          iters_q  <= iter_nxt;
          if (finish) begin
            state_q <= ST_DONE;
            conv_q  <= (acc_q == '0);
          end else begin
            state_q <= ST_READ;
            layer_q <= '0;
            iter_q  <= iter_nxt;
            acc_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q == ST_READ) || (state_q == ST_UPDATE) ||
                         (state_q == ST_WRITE) || (state_q == ST_CHECK);
  assign rd_en_o       = (state_q == ST_READ);
  assign upd_en_o      = (state_q == ST_UPDATE);
  assign wr_en_o       = (state_q == ST_WRITE);
  assign layer_o       = layer_q;
  assign converged_o   = conv_q;
  assign iters_used_o  = iters_q;
  assign synd_weight_o = weight_q;

  assert_one_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, upd_en_o, wr_en_o}));
  assert_rd_to_upd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> upd_en_o && $stable(layer_o));
  assert_upd_to_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_o |=> wr_en_o && $stable(layer_o));
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> rd_en_o && layer_o == '0);
  assert_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (iter_q < lim_q) && (lim_q <= ITER_W'(MAX_ITER)) && (lim_q != '0));
  assert_conv_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    converged_o |-> synd_weight_o == '0);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(iters_used_o) && $stable(synd_weight_o) && $stable(converged_o));
endmodule

// File: rtl/ldpc_layer_sequencer.sv
module ldpc_layer_sequencer #(
  parameter int N_LAYERS = 7,
  parameter int N_COLS   = 8,
  parameter int Z        = 32,
  parameter int ITER_W   = 5,
  parameter int MAX_ITER = 30,
  localparam int LAYER_W = $clog2(N_LAYERS),
  localparam int CW      = $clog2(Z + 1),
  localparam int WGT_W   = $clog2(N_LAYERS * Z + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               early_exit_en_i,
  input  logic [ITER_W-1:0]  iter_limit_i,
  input  logic [N_COLS*Z-1:0] col_signs_i,
  output logic               busy_o,
  output logic               rd_en_o,
  output logic               upd_en_o,
  output logic               wr_en_o,
  output logic [LAYER_W-1:0] layer_o,
  output logic               converged_o,
  output logic [ITER_W-1:0]  iters_used_o,
  output logic [WGT_W-1:0]   synd_weight_o
);
  logic [CW-1:0]     layer_fail;
  logic [ITER_W-1:0] lim_eff;

  layer_parity_unit #(.N_COLS(N_COLS), .Z(Z)) u_parity (
    .col_signs_i (col_signs_i),
    .fail_cnt_o  (layer_fail)
  );

  iter_limit_clamp #(.ITER_W(ITER_W), .MAX_ITER(MAX_ITER)) u_clamp (
    .raw_i (iter_limit_i),
    .lim_o (lim_eff)
  );

  seq_fsm #(.N_LAYERS(N_LAYERS), .Z(Z), .ITER_W(ITER_W), .MAX_ITER(MAX_ITER)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .early_en_i    (early_exit_en_i),
    .lim_i         (lim_eff),
    .layer_fail_i  (layer_fail),
    .busy_o        (busy_o),
    .rd_en_o       (rd_en_o),
    .upd_en_o      (upd_en_o),
    .wr_en_o       (wr_en_o),
    .layer_o       (layer_o),
    .converged_o   (converged_o),
    .iters_used_o  (iters_used_o),
    .synd_weight_o (synd_weight_o)
  );
endmodule

// File: tb/ldpc_layer_sequencer_test.sv
module ldpc_layer_sequencer_test;
  localparam int NL = 7, NC = 8, Z = 32;

  logic         clk = 0, rst_n = 0, start = 0, early_en = 0;
  logic [4:0]   lim_raw = 0;
  logic [255:0] col_signs = '0;
  logic         busy, rd_en, upd_en, wr_en, conv;
  logic [2:0]   layer;
  logic [4:0]   iters;
  logic [7:0]   weight;

  ldpc_layer_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .early_exit_en_i(early_en),
    .iter_limit_i(lim_raw), .col_signs_i(col_signs), .busy_o(busy),
    .rd_en_o(rd_en), .upd_en_o(upd_en), .wr_en_o(wr_en), .layer_o(layer),
    .converged_o(conv), .iters_used_o(iters), .synd_weight_o(weight)
  );

  always #2 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  running = 0, ended = 0;
  int  bcyc = 0, phase_err = 0;
  int  wtab [30][7];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [255:0] make_signs(input int w);
    logic [255:0] v;
    logic [31:0]  m, x;
    int r;
    m = 32'((64'd1 << w) - 64'd1);
    r = $urandom_range(0, 31);
    m = (m << r) | (m >> (32 - r));
    x = '0;
    for (int j = 1; j < NC; j++) begin
      v[j*Z +: Z] = $urandom;
      x = x ^ v[j*Z +: Z];
    end
    v[31:0] = m ^ x;
    return v;
  endfunction

  function automatic logic [255:0] junk();
    logic [255:0] v;
    for (int j = 0; j < 8; j++) v[j*32 +: 32] = $urandom;
    return v;
  endfunction

  // Bench model of the phase schedule and sign supply
  always @(negedge clk) begin
    if (running && busy) begin
      int c, it;
      logic er, eu, ew;
      c  = bcyc % 22;
      it = bcyc / 22;
      er = (c < 21) && (c % 3 == 0);
      eu = (c < 21) && (c % 3 == 1);
      ew = (c < 21) && (c % 3 == 2);
      if (rd_en !== er || upd_en !== eu || wr_en !== ew ||
          (c < 21 && layer !== 3'(c / 3))) phase_err++;
      if (ew && it < 30) col_signs = make_signs(wtab[it][c / 3]);
      else col_signs = junk();
      bcyc++;
    end
  end

  task automatic run_case(input int lr, input bit en, input int zero_at, input int mode,
                          input bit busy_start, input string tag);
    int lim, fin, s, k;
    lim = (lr == 0 || lr > 30) ? 30 : lr;
    for (k = 0; k < 30; k++) begin
      s = 0;
      for (int l = 0; l < NL; l++) begin
        if (mode == 1) wtab[k][l] = 0;
        else if (mode == 2) wtab[k][l] = 32;
        else if (k == zero_at) wtab[k][l] = 0;
        else wtab[k][l] = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 32);
        s += wtab[k][l];
      end
      if (mode == 0 && k != zero_at && s == 0) wtab[k][0] = 1;
    end
    fin = lim;
    for (k = 0; k < lim; k++) begin
      s = 0;
      for (int l = 0; l < NL; l++) s += wtab[k][l];
      if (en && s == 0) begin fin = k + 1; break; end
    end
    s = 0;
    for (int l = 0; l < NL; l++) s += wtab[fin-1][l];

    @(negedge clk);
    lim_raw = 5'(lr); early_en = en; start = 1; bcyc = 0; phase_err = 0; running = 1;
    @(negedge clk);
    start = 0; lim_raw = 5'($urandom); early_en = ~en;
    check(busy && rd_en && layer == 0, {tag, " R2 first read"}, {busy, rd_en, layer}, 6'b110000 >> 1);
    if (busy_start) begin
      repeat (10) @(negedge clk);
      start = 1; lim_raw = 5'd20;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    running = 0;
    check(bcyc == fin * 22, {tag, " R3 busy cycles"}, bcyc, fin * 22);
    check(phase_err == 0, {tag, " R3 phase schedule"}, phase_err, 0);
    check(int'(iters) == fin, {tag, " R8 iterations used"}, iters, fin);
    check(int'(weight) == s, {tag, " R4 syndrome weight"}, weight, s);
    check(conv == (s == 0), {tag, " R9 converged"}, conv, (s == 0));
    repeat (3) @(negedge clk);
    check(!busy && int'(iters) == fin && int'(weight) == s, {tag, " R8 outputs hold"}, iters, fin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({busy, rd_en, upd_en, wr_en, conv} == 5'b0 && iters == 0 && weight == 0,
          "R1 reset state", {busy, rd_en, upd_en, wr_en, conv}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && iters == 0, "R1 idle after reset", busy, 0);

    run_case(5,  1, 2,  0, 0, "early_R5");
    run_case(6,  1, 0,  0, 0, "first_iter_R5");
    run_case(5,  0, 2,  0, 0, "no_early_R6");
    run_case(4,  0, 99, 1, 0, "zero_noexit_R6");
    run_case(0,  0, 99, 0, 0, "lim0_R7");
    run_case(31, 1, 99, 0, 0, "lim31_R7");
    run_case(1,  1, 99, 2, 0, "full_weight_R4");
    run_case(30, 1, 29, 0, 0, "last_iter_R5");
    run_case(3,  0, 99, 0, 1, "busy_start_R10");
    run_case(7,  1, 3,  0, 1, "busy_start_early_R10");
    for (int i = 0; i < 20; i++)
      run_case($urandom_range(0, 31), 1'($urandom), $urandom_range(0, 34), 0,
               1'($urandom), "random");

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule